// File: doc/BRIEF.md
# Power-Monitor Serial Command and Readback Controller

This block is the serial-bus front end of a current and voltage monitor. It behaves as an I2C target at fast-mode rates. It oversamples SCL and SDA on the system clock and matches its 7-bit address. It then takes either a command byte or a two-byte write to one of three alert configuration registers. On reads it returns the latest 12-bit conversion codes, packed to suit the selected channels, or a single status byte. SDA is open-drain: the block drives the line low by raising `sdaOe`.

The command bits become conversion requests for an ADC sequencer. The sequencer returns each result as a one-cycle pulse that carries a channel flag and a code. One-shot requests clear themselves when the result for their channel arrives. While a one-shot conversion is still outstanding, a read is refused at the address byte. The alert-enable, alert-threshold and control registers are driven out to the alert logic, and that logic supplies the six status flags.

Top module: `pmi_top`

## Requirements
- R1: The block acknowledges an address byte only when bits 7:1 equal 01011 followed by `addrSel[1:0]`. Bit 0 is the direction, 0 for write and 1 for read. A non-matching address is not acknowledged, and the rest of that transfer is ignored.
- R2: An address-only write followed by STOP (a presence probe) is acknowledged and changes no output or register.
- R3: A first written byte with bit 7 = 0 is a command. Its bits have these meanings: bit 0 = continuous voltage, bit 1 = one-shot voltage, bit 2 = continuous current, bit 3 = one-shot current, bit 4 = voltage range (`vRange`), bit 6 = status readback. `reqVolt` is bit0|bit1 and `reqCurr` is bit2|bit3.
- R4: A one-shot bit clears once a result arrives for its channel (`adcIsCurr` 0 = voltage, 1 = current). The matching request output then falls on the next clock unless a continuous bit keeps it up.
- R5: A first written byte with bit 7 = 1 is a register pointer. Its bits 1:0 select the register for the next byte: 01 = alert enable, 10 = alert threshold, 11 = control. Pointer 00 selects nothing, so its data byte changes nothing.
- R6: After reset `sdaOe` is 0, both requests are 0, `vRange` is 0, alert enable is 0x04, alert threshold is 0xFF and control is 0x00.
- R7: Writing alert enable with bit 4 set shows bit 4 high for exactly one clock, after which it reads 0. The other bits keep the written value.
- R8: With both channels selected, a read returns V[11:4], then I[11:4], then {V[3:0], I[3:0]}.
- R9: With one channel selected, a read returns X[11:4], then {X[3:0], 4'b0000}.
- R10: With the status bit set, a read returns one byte, {2'b00, alertFlags[5:0]}.
- R11: The read address is not acknowledged while a one-shot conversion is pending. With only continuous bits set, a read before any result is acknowledged and returns zeros.
- R12: The block changes `sdaOe` only while SCL is low. It releases SDA after the master's not-acknowledge. START or STOP resets the byte engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock pin level |
| sdaIn | input | 1 | Serial data pin level |
| sdaOe | output | 1 | Pull SDA low when 1 |
| addrSel | input | 2 | Low two bits of the target address |
| adcValid | input | 1 | Conversion result strobe |
| adcIsCurr | input | 1 | Result channel: 0 voltage, 1 current |
| adcCode | input | 12 | Conversion code |
| alertFlags | input | 6 | Status flags from the alert logic |
| reqVolt | output | 1 | Voltage conversion requested |
| reqCurr | output | 1 | Current conversion requested |
| vRange | output | 1 | Voltage range select |
| alertEn | output | 8 | Alert-enable register |
| alertTh | output | 8 | Alert-threshold register |
| ctrlReg | output | 8 | Control register |

## Verification
A wrong byte-engine state usually shows up within one SCL period. Either an acknowledge lands on the wrong clock, or the bits of a returned byte are shifted, so the bench's acknowledge and data comparisons catch it in the same transfer. A wrong readback snapshot or format choice shows as a misplaced nibble or a wrong byte count on the next read. A stuck one-shot bit shows as a refused read address and a request output that never falls after the result pulse. Register-write errors are visible on the register outputs within two clocks of the data byte's acknowledge.

// File: rtl/pmi_pkg.sv
package pmi_pkg;
  localparam int ADC_W  = 12;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = ADC_W - BYTE_W;

  localparam logic [1:0] SEL_EN   = 2'b01;
  localparam logic [1:0] SEL_TH   = 2'b10;
  localparam logic [1:0] SEL_CTRL = 2'b11;

  typedef struct packed {
    logic              cmdWr;
    logic              extWr;
    logic [1:0]        extSel;
    logic [BYTE_W-1:0] wrData;
    logic              snap;
  } ctlStb_t;
endpackage

// File: rtl/pmi_sync.sv
module pmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev, sdaPrev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) begin
            sclPipe[0] <= 1'b1;
            sdaPipe[0] <= 1'b1;
          end else begin
            sclPipe[0] <= sclIn;
            sdaPipe[0] <= sdaIn;
          end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) begin
            sclPipe[g] <= 1'b1;
            sdaPipe[g] <= 1'b1;
          end else begin
            sclPipe[g] <= sclPipe[g-1];
            sdaPipe[g] <= sdaPipe[g-1];
          end
      end
    end
  endgenerate

  assign sclS = sclPipe[STAGES-1];
  assign sdaS = sdaPipe[STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/pmi_ctrl.sv
module pmi_ctrl
  import pmi_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE = 5'b01011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [1:0]        addrSel,
  input  logic              oneShotPend,
  input  logic [BYTE_W-1:0] rdByte,
  output logic [1:0]        rdIdx,
  output ctlStb_t           stb,
  output logic              sdaOe
);
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_RX, S_ACKPREP, S_ACK, S_TX, S_MACK, S_TXLOAD
  } state_t;

  state_t            state;
  logic [2:0]        bitCnt;
  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] txReg;
  logic [BYTE_W-1:0] shNew;
  logic              isRead, ackVal, mAck, extArmed;
  logic [1:0]        extPtr;
  logic              addrMatch;

  assign shNew     = {shReg[BYTE_W-2:0], sdaS};
  assign addrMatch = (shNew[BYTE_W-1:1] == {ADDR_BASE, addrSel});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      shReg    <= '0;
      txReg    <= '0;
      isRead   <= 1'b0;
      ackVal   <= 1'b0;
      mAck     <= 1'b0;
      extArmed <= 1'b0;
      extPtr   <= '0;
      rdIdx    <= '0;
      sdaOe    <= 1'b0;
      stb      <= '0;
    end else begin
      stb.cmdWr <= 1'b0;
      stb.extWr <= 1'b0;
      stb.snap  <= 1'b0;
      if (startDet) begin
        state    <= S_ADDR;
        bitCnt   <= '0;
        sdaOe    <= 1'b0;
        extArmed <= 1'b0;
        rdIdx    <= '0;
      end else if (stopDet) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else begin
        unique case (state)
          S_ADDR, S_RX: if (sclRise) begin
            shReg  <= shNew;
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              state <= S_ACKPREP;
              if (state == S_ADDR) begin
                isRead <= shNew[0];
                ackVal <= addrMatch & ~(shNew[0] & oneShotPend);
                stb.snap <= addrMatch & shNew[0] & ~oneShotPend;
                rdIdx  <= '0;
              end else begin
                ackVal <= 1'b1;
                if (rdIdx == 2'd0) begin
                  if (!shNew[BYTE_W-1]) begin
                    stb.cmdWr  <= 1'b1;
                    stb.wrData <= shNew;
                  end else begin
                    extArmed <= 1'b1;
                    extPtr   <= shNew[1:0];
                  end
                end else if (rdIdx == 2'd1 && extArmed && extPtr != 2'b00) begin
                  stb.extWr  <= 1'b1;
                  stb.extSel <= extPtr;
                  stb.wrData <= shNew;
                end
                if (rdIdx != 2'd3) rdIdx <= rdIdx + 2'd1;
              end
            end
          end
          S_ACKPREP: if (sclFall) begin
            sdaOe <= ackVal;
            state <= S_ACK;
          end
          S_ACK: if (sclFall) begin
            bitCnt <= '0;
            if (!ackVal) begin
              sdaOe <= 1'b0;
              state <= S_IDLE;
            end else if (isRead) begin
              txReg <= rdByte;
              sdaOe <= ~rdByte[BYTE_W-1];
              state <= S_TX;
            end else begin
              sdaOe <= 1'b0;
              state <= S_RX;
            end
          end
          S_TX: if (sclFall) begin
            if (bitCnt == 3'd7) begin
              sdaOe <= 1'b0;
              state <= S_MACK;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              txReg  <= {txReg[BYTE_W-2:0], 1'b0};
              sdaOe  <= ~txReg[BYTE_W-2];
            end
          end
          S_MACK: begin
            if (sclRise) mAck <= ~sdaS;
            if (sclFall) begin
              if (mAck) begin
                if (rdIdx != 2'd3) rdIdx <= rdIdx + 2'd1;
                state <= S_TXLOAD;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_TXLOAD: begin
            txReg  <= rdByte;
            sdaOe  <= ~rdByte[BYTE_W-1];
            bitCnt <= '0;
            state  <= S_TX;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pmi_datapath.sv
module pmi_datapath
  import pmi_pkg::*;
#(
  parameter logic [BYTE_W-1:0] EN_RST = 8'h04,
  parameter logic [BYTE_W-1:0] TH_RST = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic              adcValid,
  input  logic              adcIsCurr,
  input  logic [ADC_W-1:0]  adcCode,
  input  logic [5:0]        alertFlags,
  input  logic [1:0]        rdIdx,
  output logic [BYTE_W-1:0] rdByte,
  output logic              oneShotPend,
  output logic              reqVolt,
  output logic              reqCurr,
  output logic              vRange,
  output logic [BYTE_W-1:0] alertEn,
  output logic [BYTE_W-1:0] alertTh,
  output logic [BYTE_W-1:0] ctrlReg
);
  localparam int FRAME_N = 3;
  localparam int CLR_BIT = 4;

  logic contV, oneV, contI, oneI, statSel, fmtV, fmtI;
  logic [ADC_W-1:0]  vCode, iCode;
  logic [BYTE_W-1:0] frame [FRAME_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      contV <= 1'b0; oneV <= 1'b0; contI <= 1'b0; oneI <= 1'b0;
      vRange <= 1'b0; statSel <= 1'b0; fmtV <= 1'b0; fmtI <= 1'b0;
    end else if (stb.cmdWr) begin
      contV   <= stb.wrData[0];
      oneV    <= stb.wrData[1];
      contI   <= stb.wrData[2];
      oneI    <= stb.wrData[3];
      vRange  <= stb.wrData[4];
      statSel <= stb.wrData[6];
      fmtV    <= stb.wrData[0] | stb.wrData[1];
      fmtI    <= stb.wrData[2] | stb.wrData[3];
    end else if (adcValid) begin
      if (adcIsCurr) oneI <= 1'b0;
      else           oneV <= 1'b0;
    end
  end

  assign reqVolt     = contV | oneV;
  assign reqCurr     = contI | oneI;
  assign oneShotPend = oneV | oneI;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vCode <= '0;
      iCode <= '0;
    end else if (adcValid) begin
      if (adcIsCurr) iCode <= adcCode;
      else           vCode <= adcCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alertEn <= EN_RST;
      alertTh <= TH_RST;
      ctrlReg <= '0;
    end else begin
      if (stb.extWr && stb.extSel == SEL_EN) alertEn <= stb.wrData;
      else                                   alertEn[CLR_BIT] <= 1'b0;
      if (stb.extWr && stb.extSel == SEL_TH)   alertTh <= stb.wrData;
      if (stb.extWr && stb.extSel == SEL_CTRL) ctrlReg <= stb.wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < FRAME_N; k++) frame[k] <= '0;
    end else if (stb.snap) begin
      if (statSel) begin
        frame[0] <= {2'b00, alertFlags};
        frame[1] <= '0;
        frame[2] <= '0;
      end else if (fmtV && fmtI) begin
        frame[0] <= vCode[ADC_W-1:NIB_W];
        frame[1] <= iCode[ADC_W-1:NIB_W];
        frame[2] <= {vCode[NIB_W-1:0], iCode[NIB_W-1:0]};
      end else if (fmtI) begin
        frame[0] <= iCode[ADC_W-1:NIB_W];
        frame[1] <= {iCode[NIB_W-1:0], {NIB_W{1'b0}}};
        frame[2] <= '0;
      end else begin
        frame[0] <= vCode[ADC_W-1:NIB_W];
        frame[1] <= {vCode[NIB_W-1:0], {NIB_W{1'b0}}};
        frame[2] <= '0;
      end
    end
  end

  assign rdByte = (rdIdx < 2'(FRAME_N)) ? frame[rdIdx] : '0;
endmodule

// File: rtl/pmi_top.sv
module pmi_top
  import pmi_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE   = 5'b01011,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [1:0]        addrSel,
  input  logic              adcValid,
  input  logic              adcIsCurr,
  input  logic [ADC_W-1:0]  adcCode,
  input  logic [5:0]        alertFlags,
  output logic              reqVolt,
  output logic              reqCurr,
  output logic              vRange,
  output logic [BYTE_W-1:0] alertEn,
  output logic [BYTE_W-1:0] alertTh,
  output logic [BYTE_W-1:0] ctrlReg
);
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic oneShotPend;
  logic [1:0] rdIdx;
  logic [BYTE_W-1:0] rdByte;
  ctlStb_t stb;

  pmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  pmi_ctrl #(.ADDR_BASE(ADDR_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .addrSel(addrSel),
    .oneShotPend(oneShotPend), .rdByte(rdByte), .rdIdx(rdIdx),
    .stb(stb), .sdaOe(sdaOe)
  );

  pmi_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .adcValid(adcValid),
    .adcIsCurr(adcIsCurr), .adcCode(adcCode), .alertFlags(alertFlags),
    .rdIdx(rdIdx), .rdByte(rdByte), .oneShotPend(oneShotPend),
    .reqVolt(reqVolt), .reqCurr(reqCurr), .vRange(vRange),
    .alertEn(alertEn), .alertTh(alertTh), .ctrlReg(ctrlReg)
  );

  logic unusedSclS;
  assign unusedSclS = sclS;
endmodule

// File: rtl/pmi_checker.sv
module pmi_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic       adcValid,
  input logic       adcIsCurr,
  input logic       reqVolt,
  input logic       reqCurr,
  input logic       cmdWr,
  input logic       extWr,
  input logic [7:0] alertEn,
  input logic [7:0] alertTh
);
  // R12
  sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $changed(sdaOe) |-> !sclIn);

  // R7
  clear_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    alertEn[4] |=> !alertEn[4]);

  // R4
  volt_req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqVolt) |-> ($past(cmdWr) || $past(adcValid && !adcIsCurr)));

  // R3
  curr_req_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqCurr) |-> $past(cmdWr));

  // R5
  th_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(extWr) |-> $stable(alertTh));
endmodule

bind pmi_top pmi_checker u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .adcValid(adcValid), .adcIsCurr(adcIsCurr),
  .reqVolt(reqVolt), .reqCurr(reqCurr),
  .cmdWr(stb.cmdWr), .extWr(stb.extWr),
  .alertEn(alertEn), .alertTh(alertTh)
);

// File: tb/pmi_top_tb.sv
module pmi_top_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, sdaLine;
  logic [1:0] addrSel = 2'b10;
  logic adcValid = 1'b0, adcIsCurr = 1'b0;
  logic [11:0] adcCode = '0;
  logic [5:0] alertFlags = '0;
  logic reqVolt, reqCurr, vRange;
  logic [7:0] alertEn, alertTh, ctrlReg;

  int nChecks = 0, nFails = 0, clrCycles = 0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] obsQ[$];

  always #10 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  pmi_top u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrSel(addrSel), .adcValid(adcValid), .adcIsCurr(adcIsCurr),
    .adcCode(adcCode), .alertFlags(alertFlags), .reqVolt(reqVolt),
    .reqCurr(reqCurr), .vRange(vRange), .alertEn(alertEn),
    .alertTh(alertTh), .ctrlReg(ctrlReg)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // monitor: pops observed bus items and compares with expectations
  initial forever begin
    @(negedge clk);
    while (obsQ.size() > 0) begin
      logic [7:0] o;
      o = obsQ.pop_front();
      if (expQ.size() == 0) check("unexpected item", o, 0);
      else check(tagQ.pop_front(), o, expQ.pop_front());
    end
  end

  always @(negedge clk) if (alertEn[4]) clrCycles++;

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic putBit(input logic b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    b = sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  // driver: pushes the expected ack (0 = ack) then sends the byte
  task automatic wrByte(input logic [7:0] d, input logic expNack, input string tag);
    logic a;
    expQ.push_back({7'b0, expNack}); tagQ.push_back(tag);
    for (int i = 7; i >= 0; i--) putBit(d[i]);
    getBit(a);
    obsQ.push_back({7'b0, a});
  endtask

  task automatic rdByte(input logic [7:0] exp, input logic last, input string tag);
    logic [7:0] d;
    expQ.push_back(exp); tagQ.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      getBit(b);
      d[i] = b;
    end
    obsQ.push_back(d);
    putBit(last);
  endtask

  task automatic sendCmd(input logic [7:0] c);
    busStart(); wrByte(8'h5C, 1'b0, "R1 addr ack"); wrByte(c, 1'b0, "R3 cmd ack"); busStop();
  endtask

  task automatic extWrite(input logic [7:0] p, input logic [7:0] d);
    busStart(); wrByte(8'h5C, 1'b0, "R1 addr ack");
    wrByte(p, 1'b0, "R5 ptr ack"); wrByte(d, 1'b0, "R5 data ack"); busStop();
  endtask

  task automatic adcPulse(input logic isCurr, input logic [11:0] code);
    @(negedge clk); adcValid = 1'b1; adcIsCurr = isCurr; adcCode = code;
    @(negedge clk); adcValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20ns * 150000);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R6 reset state
    check("R6 sdaOe", sdaOe, 0);
    check("R6 reqVolt", reqVolt, 0);
    check("R6 reqCurr", reqCurr, 0);
    check("R6 vRange", vRange, 0);
    check("R6 alertEn", alertEn, 8'h04);
    check("R6 alertTh", alertTh, 8'hFF);
    check("R6 ctrlReg", ctrlReg, 8'h00);

    // R2 presence probe
    busStart(); wrByte(8'h5C, 1'b0, "R2 probe ack"); busStop();
    check("R2 reqVolt", reqVolt, 0);
    check("R2 alertTh", alertTh, 8'hFF);
    check("R2 alertEn", alertEn, 8'h04);

    // R1 wrong address, then a command byte that must be ignored
    busStart(); wrByte(8'h58, 1'b1, "R1 wrong addr nack"); wrByte(8'h05, 1'b1, "R1 ignored byte"); busStop();
    check("R1 ignored reqVolt", reqVolt, 0);
    check("R12 released", sdaOe, 0);

    // R3 continuous both; R11 zeros before first result
    sendCmd(8'h05);
    check("R3 reqVolt", reqVolt, 1);
    check("R3 reqCurr", reqCurr, 1);
    busStart(); wrByte(8'h5D, 1'b0, "R11 cont read ack");
    rdByte(8'h00, 1'b0, "R11 zero b0"); rdByte(8'h00, 1'b0, "R11 zero b1");
    rdByte(8'h00, 1'b1, "R11 zero b2"); busStop();
    check("R12 released after nack", sdaOe, 0);

    // R8 three-byte layout
    adcPulse(1'b0, 12'hABC);
    adcPulse(1'b1, 12'h123);
    busStart(); wrByte(8'h5D, 1'b0, "R8 addr ack");
    rdByte(8'hAB, 1'b0, "R8 V hi"); rdByte(8'h12, 1'b0, "R8 I hi");
    rdByte(8'hC3, 1'b1, "R8 nibbles"); busStop();

    // R4 / R11 one-shot voltage
    sendCmd(8'h02);
    check("R3 oneshot reqVolt", reqVolt, 1);
    check("R3 oneshot reqCurr", reqCurr, 0);
    busStart(); wrByte(8'h5D, 1'b1, "R11 pending nack"); busStop();
    adcPulse(1'b1, 12'h777);
    check("R4 other channel keeps req", reqVolt, 1);
    adcPulse(1'b0, 12'h5A7);
    check("R4 reqVolt cleared", reqVolt, 0);
    busStart(); wrByte(8'h5D, 1'b0, "R11 done ack");
    rdByte(8'h5A, 1'b0, "R9 V hi"); rdByte(8'h70, 1'b1, "R9 V lo"); busStop();

    // R9 current only one-shot
    sendCmd(8'h08);
    check("R3 reqCurr oneshot", reqCurr, 1);
    adcPulse(1'b1, 12'hFED);
    check("R4 reqCurr cleared", reqCurr, 0);
    busStart(); wrByte(8'h5D, 1'b0, "R9 addr ack");
    rdByte(8'hFE, 1'b0, "R9 I hi"); rdByte(8'hD0, 1'b1, "R9 I lo"); busStop();

    // R5 extended registers
    extWrite(8'h82, 8'h3C);
    check("R5 alertTh", alertTh, 8'h3C);
    extWrite(8'h83, 8'h01);
    check("R5 ctrlReg", ctrlReg, 8'h01);
    clrCycles = 0;
    extWrite(8'h81, 8'h13);
    check("R7 alertEn after clear", alertEn, 8'h03);
    check("R7 clear width", clrCycles, 1);
    extWrite(8'h80, 8'h55);
    check("R5 null ptr th", alertTh, 8'h3C);
    check("R5 null ptr en", alertEn, 8'h03);
    check("R5 null ptr ctrl", ctrlReg, 8'h01);
    check("R5 cmd untouched", reqCurr, 0);

    // R10 status readback, R3 range bit
    alertFlags = 6'h2A;
    sendCmd(8'h50);
    check("R3 vRange", vRange, 1);
    busStart(); wrByte(8'h5D, 1'b0, "R10 addr ack");
    rdByte(8'h2A, 1'b1, "R10 status"); busStop();
    check("R12 idle", sdaOe, 0);

    repeat (20) @(negedge clk);
    if (expQ.size() != 0) check("scoreboard drained", expQ.size(), 0);
    summary();
  end
endmodule